// File: doc/BRIEF.md
# Banked BCD Calendar Clock

This block is a real-time calendar counter that keeps every time field as its own 4-bit BCD digit. It covers seconds, minutes, 24-hour hours, a day-of-week counter, day of month, month and a four-digit year. Software reaches the digits through a small parallel register port with a 4-bit address and 4-bit data. One location, 0xF, is a control register that is present in every bank. It carries a read-only busy flag, a stop bit and a 2-bit bank selector. Bank 0 shows the running calendar.

An external pulse input drives the count. A prescaler turns every `TICK_DIV` accepted pulses into one second. Each second then walks a carry sequencer through six stages: seconds, minutes, hours, day, month, year. The states are ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MON and ST_YEAR. The only branching transition is ST_IDLE to ST_SEC on a second pulse. Every other state always steps to the next one, and ST_YEAR returns to ST_IDLE. The busy flag is high in every state other than ST_IDLE. Software polls it until it reads 0 before it samples the time. To set the clock, software sets stop, writes the digits and clears stop. Clearing stop also restarts the prescaler.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the clock reads 2000-01-01 00:00:00 with day of week 0, and the control register reads 0, so stop is 0, bank is 0 and busy is 0.
- R2: Address 0xF reads as {bank[1:0] in bits 3:2, stop in bit 1, busy in bit 0} in every bank. A write there loads bank and stop from data bits 3:2 and 1. Bit 0 is read-only and a write to it has no effect.
- R3: In bank 0, addresses 0x0..0xE read these digits: 0 sec ones, 1 sec tens, 2 min ones, 3 min tens, 4 hour ones, 5 hour tens, 6 day of week, 7 day ones, 8 day tens, 9 month ones, 0xA month tens, 0xB..0xE year ones, tens, hundreds and thousands.
- R4: When the bank is 1, 2 or 3, addresses 0x0..0xE read 0 and writes to them change no digit.
- R5: The calendar advances one second on every TICK_DIV-th pulse that is accepted, and earlier pulses leave it unchanged.
- R6: Busy reads 1 for exactly 6 clock cycles. It rises in the cycle after the edge that accepts the completing pulse. The advanced time can be read once busy reads 0.
- R7: Seconds and minutes roll from 59 to 00 with a carry, and hours roll from 23 to 00 with a carry. Each day carry advances the day of week, which wraps from 6 to 0.
- R8: The day of month rolls to 01 after day 30 in April, June, September and November, and after day 31 in the other months except February.
- R9: February ends on day 29 when the year is divisible by 4, except that a year divisible by 100 is a leap year only if it is also divisible by 400. Otherwise February ends on day 28.
- R10: Month 12 rolls to 01 with a carry into the year, and the year rolls from 9999 to 0000.
- R11: While stop is 1, pulses are ignored and the prescaler does not count. Writing stop from 1 to 0 clears the prescaler.
- R12: A digit write in bank 0 takes effect at once when stop is 1 and busy is 0. When stop is 0 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count pulse, one clock wide |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 4 | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_rdata_o | output | 4 | Read data, combinational from the address |

## Verification
The bench builds the clock with TICK_DIV = 3, so that one second needs three pulses. With that value the bench can show that partial pulse counts leave the time unchanged. It can also show that releasing stop discards a partly filled prescaler, which a divider of 1 would hide. The default register width keeps all fifteen digits and every rollover, up to 9999-12-31 23:59:59, within reach. Directed dates cover each month length and the century leap cases. Seeded random dates placed near the ends of minutes, hours and months exercise mixed carries.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int DIG_W      = 4;
    localparam int NUM_DIGITS = 15;
    localparam int ADDR_W     = 4;
    localparam int BANK_W     = 2;
    localparam int STAGES     = 6;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'hF;

    // digit slots (the bank 0 address equals the slot index)
    localparam int IX_SEC1 = 0;
    localparam int IX_SEC10 = 1;
    localparam int IX_MIN1 = 2;
    localparam int IX_MIN10 = 3;
    localparam int IX_HR1 = 4;
    localparam int IX_HR10 = 5;
    localparam int IX_WDAY = 6;
    localparam int IX_DAY1 = 7;
    localparam int IX_DAY10 = 8;
    localparam int IX_MON1 = 9;
    localparam int IX_MON10 = 10;
    localparam int IX_YR1 = 11;
    localparam int IX_YR1000 = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MON,
        ST_YEAR
    } ripple_state_t;

    typedef logic [NUM_DIGITS-1:0][DIG_W-1:0] digit_vec_t;

    function automatic logic [7:0] bcd_val(input logic [3:0] hi, input logic [3:0] lo);
        return 8'(hi) * 8'd10 + 8'(lo);
    endfunction

    // {carry, hi, lo} after one increment of a two-digit field
    function automatic logic [8:0] bcd_step(input logic [3:0] hi, input logic [3:0] lo,
                                            input logic [7:0] last, input logic [3:0] first_lo);
        if (bcd_val(hi, lo) >= last)
            return {1'b1, 4'd0, first_lo};
        else if (lo >= 4'd9)
            return {1'b0, hi + 4'd1, 4'd0};
        else
            return {1'b0, hi, lo + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [3:0] y1000, input logic [3:0] y100,
                                     input logic [3:0] y10, input logic [3:0] y1);
        logic [7:0] lo2;
        logic [7:0] hi2;
        lo2 = bcd_val(y10, y1);
        hi2 = bcd_val(y1000, y100);
        if (lo2 == 8'd0)
            return hi2[1:0] == 2'b00;
        return lo2[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic leap);
        unique case (mon)
            8'd2:                      return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

    // power-on calendar: 2000-01-01 00:00:00, weekday 0
    function automatic logic [DIG_W-1:0] reset_digit(input int idx);
        unique case (idx)
            IX_DAY1, IX_MON1: return 4'd1;
            IX_YR1000:        return 4'd2;
            default:          return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
    parameter int TICK_DIV = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic enable_i,
    input  logic clear_i,
    output logic sec_pulse_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          take;

    assign take        = tick_i & enable_i;
    assign sec_pulse_o = take & (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (take)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
endmodule

// File: rtl/cal_ripple_seq.sv
module cal_ripple_seq
    import bcdcal_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          carry_i,
    output ripple_state_t state_o,
    output logic          carry_o,
    output logic          busy_o
);
    ripple_state_t state_q, state_d;
    logic          carry_q, carry_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            carry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            carry_q <= carry_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        carry_d = carry_i;
        unique case (state_q)
            ST_IDLE: begin
                carry_d = start_i;
                if (start_i) state_d = ST_SEC;
            end
            ST_SEC:  state_d = ST_MIN;
            ST_MIN:  state_d = ST_HOUR;
            ST_HOUR: state_d = ST_DAY;
            ST_DAY:  state_d = ST_MON;
            ST_MON:  state_d = ST_YEAR;
            ST_YEAR: begin
                state_d = ST_IDLE;
                carry_d = 1'b0;
            end
            default: begin
                state_d = ST_IDLE;
                carry_d = 1'b0;
            end
        endcase
    end

    // outputs
    always_comb begin
        state_o = state_q;
        carry_o = carry_q;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            default: busy_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/cal_digit_bank.sv
module cal_digit_bank
    import bcdcal_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  ripple_state_t         state_i,
    input  logic                  carry_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_idx_i,
    input  logic [DIG_W-1:0]      wr_data_i,
    output digit_vec_t            digits_o,
    output logic                  carry_o
);
    digit_vec_t dig_q, dig_d;
    logic       leap;
    logic [7:0] last_day;

    assign leap     = is_leap(dig_q[IX_YR1000], dig_q[IX_YR1000-1], dig_q[IX_YR1+1], dig_q[IX_YR1]);
    assign last_day = month_last_day(bcd_val(dig_q[IX_MON10], dig_q[IX_MON1]), leap);

    always_comb begin
        logic [8:0] step;
        logic       yc;
        dig_d   = dig_q;
        carry_o = 1'b0;
        step    = '0;
        yc      = carry_i;
        unique case (state_i)
            ST_SEC: if (carry_i) begin
                step = bcd_step(dig_q[IX_SEC10], dig_q[IX_SEC1], 8'd59, 4'd0);
                {carry_o, dig_d[IX_SEC10], dig_d[IX_SEC1]} = step;
            end
            ST_MIN: if (carry_i) begin
                step = bcd_step(dig_q[IX_MIN10], dig_q[IX_MIN1], 8'd59, 4'd0);
                {carry_o, dig_d[IX_MIN10], dig_d[IX_MIN1]} = step;
            end
            ST_HOUR: if (carry_i) begin
                step = bcd_step(dig_q[IX_HR10], dig_q[IX_HR1], 8'd23, 4'd0);
                {carry_o, dig_d[IX_HR10], dig_d[IX_HR1]} = step;
            end
            ST_DAY: if (carry_i) begin
                dig_d[IX_WDAY] = (dig_q[IX_WDAY] >= 4'd6) ? 4'd0 : dig_q[IX_WDAY] + 4'd1;
                step = bcd_step(dig_q[IX_DAY10], dig_q[IX_DAY1], last_day, 4'd1);
                {carry_o, dig_d[IX_DAY10], dig_d[IX_DAY1]} = step;
            end
            ST_MON: if (carry_i) begin
                step = bcd_step(dig_q[IX_MON10], dig_q[IX_MON1], 8'd12, 4'd1);
                {carry_o, dig_d[IX_MON10], dig_d[IX_MON1]} = step;
            end
            ST_YEAR: begin
                for (int i = IX_YR1; i <= IX_YR1000; i++) begin
                    if (yc) begin
                        if (dig_q[i] >= 4'd9) begin
                            dig_d[i] = 4'd0;
                        end else begin
                            dig_d[i] = dig_q[i] + 4'd1;
                            yc = 1'b0;
                        end
                    end
                end
            end
            default: ;
        endcase
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (wr_en_i && wr_idx_i == ADDR_W'(i))
                dig_d[i] = wr_data_i;
        end
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                dig_q[g] <= reset_digit(g);
            else
                dig_q[g] <= dig_d[g];
        end
    end

    assign digits_o = dig_q;
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
    import bcdcal_pkg::*;
#(
    parameter int TICK_DIV = 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        tick_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [3:0]  bus_wdata_i,
    input  logic        bus_we_i,
    output logic [3:0]  bus_rdata_o
);
    logic                 stop_q;
    logic [BANK_W-1:0]    bank_q;
    logic                 busy;
    logic                 sec_pulse;
    logic                 ctrl_wr;
    logic                 pre_clear;
    logic                 dig_wr;
    logic                 stage_carry;
    logic                 stage_carry_out;
    ripple_state_t        state;
    digit_vec_t           digits;
    logic [15:0][DIG_W-1:0] rd_vec;

    assign ctrl_wr   = bus_we_i && (bus_addr_i == CTRL_ADDR);
    assign pre_clear = ctrl_wr && stop_q && !bus_wdata_i[1];
    assign dig_wr    = bus_we_i && (bus_addr_i != CTRL_ADDR) && (bank_q == '0) && stop_q && !busy;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stop_q <= 1'b0;
            bank_q <= '0;
        end else if (ctrl_wr) begin
            stop_q <= bus_wdata_i[1];
            bank_q <= bus_wdata_i[3:2];
        end
    end

    cal_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .enable_i   (!stop_q && !busy),
        .clear_i    (pre_clear),
        .sec_pulse_o(sec_pulse)
    );

    cal_ripple_seq u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(sec_pulse),
        .carry_i(stage_carry_out),
        .state_o(state),
        .carry_o(stage_carry),
        .busy_o (busy)
    );

    cal_digit_bank u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .state_i  (state),
        .carry_i  (stage_carry),
        .wr_en_i  (dig_wr),
        .wr_idx_i (bus_addr_i),
        .wr_data_i(bus_wdata_i),
        .digits_o (digits),
        .carry_o  (stage_carry_out)
    );

    assign rd_vec[14:0] = digits;
    assign rd_vec[15]   = {bank_q, stop_q, busy};

    always_comb begin
        if (bus_addr_i == CTRL_ADDR || bank_q == '0)
            bus_rdata_o = rd_vec[bus_addr_i];
        else
            bus_rdata_o = '0;
    end
endmodule

// File: rtl/bcdcal_checker.sv
module bcdcal_checker
    import bcdcal_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              busy_i,
    input logic              stop_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [3:0]        addr_i,
    input logic [3:0]        wdata_i,
    input logic              we_i,
    input logic [3:0]        rdata_i,
    input ripple_state_t     state_i,
    input digit_vec_t        digits_i
);
    logic [3:0] busy_len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            busy_len_q <= '0;
        else
            busy_len_q <= busy_i ? busy_len_q + 4'd1 : 4'd0;
    end

    assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_i) |-> busy_len_q == 4'(STAGES));

    assert_ctrl_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == CTRL_ADDR) |=> (stop_i == $past(wdata_i[1]) && bank_i == $past(wdata_i[3:2])));

    assert_bank_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bank_i != '0 && addr_i != CTRL_ADDR) |-> rdata_i == 4'd0);

    assert_stop_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !busy_i && !we_i) |=> $stable(digits_i));

    assert_run_nowrite_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stop_i && !busy_i && we_i) |=> $stable(digits_i));

    assert_sec_digit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_SEC) |=> digits_i[IX_SEC1] <= 4'd9);
endmodule

bind bcd_cal_clock bcdcal_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy),
    .stop_i  (stop_q),
    .bank_i  (bank_q),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .we_i    (bus_we_i),
    .rdata_i (bus_rdata_o),
    .state_i (state),
    .digits_i(digits)
);

// File: tb/bcd_cal_clock_tb.sv
module bcd_cal_clock_tb;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [3:0] wdata = 4'd0;
    logic       we = 1'b0;
    logic [3:0] rdata;

    int errs = 0;
    int checks = 0;
    int m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr;

    always #2 clk = ~clk;

    bcd_cal_clock #(.TICK_DIV(DIV)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata)
    );

    function automatic int mlen(int mo, int y);
        bit lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic adv_model();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin
            m_hr = 0; m_wd = (m_wd >= 6) ? 0 : m_wd + 1; m_day++;
            if (m_day > mlen(m_mon, m_yr)) begin m_day = 1; m_mon++; end
            if (m_mon == 13) begin m_mon = 1; m_yr++; end
            if (m_yr == 10000) m_yr = 0;
        end
    endtask

    function automatic logic [3:0] exp_dig(int a);
        case (a)
            0: return 4'(m_sec % 10);   1: return 4'(m_sec / 10);
            2: return 4'(m_min % 10);   3: return 4'(m_min / 10);
            4: return 4'(m_hr % 10);    5: return 4'(m_hr / 10);
            6: return 4'(m_wd);
            7: return 4'(m_day % 10);   8: return 4'(m_day / 10);
            9: return 4'(m_mon % 10);   10: return 4'(m_mon / 10);
            11: return 4'(m_yr % 10);   12: return 4'((m_yr / 10) % 10);
            13: return 4'((m_yr / 100) % 10);
            default: return 4'(m_yr / 1000);
        endcase
    endfunction

    task automatic chk(string req, logic [59:0] act, logic [59:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [3:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [3:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic check_time(string req);
        logic [59:0] act, exp;
        logic [3:0] d;
        for (int a = 0; a < 15; a++) begin
            rd(4'(a), d);
            act[a*4 +: 4] = d;
            exp[a*4 +: 4] = exp_dig(a);
        end
        chk(req, act, exp);
    endtask

    task automatic set_time(int s, int mi, int h, int wd, int d, int mo, int y);
        m_sec = s; m_min = mi; m_hr = h; m_wd = wd; m_day = d; m_mon = mo; m_yr = y;
        wr(4'hF, 4'b0010);
        for (int a = 0; a < 15; a++) wr(4'(a), exp_dig(a));
        wr(4'hF, 4'b0000);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic one_second();
        pulses(DIV);
        adv_model();
    endtask

    task automatic roll(string req, int s, int mi, int h, int wd, int d, int mo, int y);
        set_time(s, mi, h, wd, d, mo, y);
        one_second();
        check_time(req);
    endtask

    initial begin
        #(200000 * 4);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [3:0] d;
        int cnt;
        void'($urandom(32'd2468));
        m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_day = 1; m_mon = 1; m_yr = 2000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset calendar and control
        check_time("R1");
        rd(4'hF, d); chk("R1 ctrl", 60'(d), 60'd0);

        // R2 control fields, busy bit read-only
        wr(4'hF, 4'b0110); rd(4'hF, d); chk("R2 bank1 stop", 60'(d), 60'h6);
        wr(4'hF, 4'b1100); rd(4'hF, d); chk("R2 bank3", 60'(d), 60'hC);
        wr(4'hF, 4'b0001); rd(4'hF, d); chk("R2 busy ro", 60'(d), 60'h0);

        // R4 other banks read zero, writes dropped
        wr(4'hF, 4'b0110); rd(4'h0, d); chk("R4 read", 60'(d), 60'h0);
        rd(4'hE, d); chk("R4 read hi", 60'(d), 60'h0);
        wr(4'h0, 4'd5); wr(4'hF, 4'b0010); wr(4'hF, 4'b0000);
        check_time("R4 write dropped");

        // R12 running write ignored, stopped write taken
        wr(4'h0, 4'd7); check_time("R12 running");
        wr(4'hF, 4'b0010); wr(4'h0, 4'd4); m_sec = 4;
        rd(4'h0, d); chk("R12 stopped", 60'(d), 60'h4);
        wr(4'hF, 4'b0000);

        // R3 digit mapping
        set_time(34, 12, 9, 3, 15, 7, 2016);
        check_time("R3");

        // R5 prescaler division
        pulses(DIV - 1); check_time("R5 partial");
        pulses(1); adv_model(); check_time("R5 complete");

        // R6 busy window
        pulses(DIV - 1);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; addr = 4'hF; #1;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (rdata[0]) cnt++;
            @(negedge clk); #1;
        end
        chk("R6 busy cycles", 60'(cnt), 60'd6);
        adv_model(); check_time("R6 result");

        // R7 time rollovers and weekday wrap
        roll("R7 midnight", 59, 59, 23, 6, 10, 5, 2023);
        roll("R7 hour", 59, 59, 9, 2, 10, 5, 2023);
        roll("R7 minute", 59, 41, 13, 2, 10, 5, 2023);

        // R8 month lengths
        roll("R8 april", 59, 59, 23, 1, 30, 4, 2023);
        roll("R8 january", 59, 59, 23, 1, 31, 1, 2023);
        roll("R8 may 30", 59, 59, 23, 1, 30, 5, 2023);

        // R9 leap years
        roll("R9 2024-02-28", 59, 59, 23, 4, 28, 2, 2024);
        roll("R9 2024-02-29", 59, 59, 23, 4, 29, 2, 2024);
        roll("R9 2023-02-28", 59, 59, 23, 4, 28, 2, 2023);
        roll("R9 2100-02-28", 59, 59, 23, 4, 28, 2, 2100);
        roll("R9 2000-02-28", 59, 59, 23, 4, 28, 2, 2000);

        // R10 year rollovers
        roll("R10 new year", 59, 59, 23, 0, 31, 12, 2023);
        roll("R10 9999", 59, 59, 23, 0, 31, 12, 9999);

        // R11 stop blocks pulses, release clears prescaler
        set_time(10, 20, 5, 1, 3, 3, 2030);
        wr(4'hF, 4'b0010); pulses(5); wr(4'hF, 4'b0000);
        check_time("R11 stopped");
        pulses(DIV - 1); wr(4'hF, 4'b0010); wr(4'hF, 4'b0000);
        pulses(DIV - 1); check_time("R11 cleared");
        pulses(1); adv_model(); check_time("R11 resumed");

        // seeded random dates near rollovers
        for (int it = 0; it < 30; it++) begin
            int s, mi, h, wd, mo, y, dd, k;
            s  = 50 + int'($urandom % 10);
            mi = ($urandom % 2) ? 59 : int'($urandom % 60);
            h  = ($urandom % 2) ? 23 : int'($urandom % 24);
            wd = int'($urandom % 7);
            mo = 1 + int'($urandom % 12);
            y  = int'($urandom % 10000);
            dd = mlen(mo, y) - int'($urandom % 3);
            k  = 1 + int'($urandom % 3);
            set_time(s, mi, h, wd, dd, mo, y);
            for (int j = 0; j < k; j++) one_second();
            check_time("R3 R7 R8 R9 R10 random");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule